// File: doc/BRIEF.md
# Converter Result Bus Port

This block connects the latched result of an analog-to-digital converter to an 8-bit microprocessor data bus. When the sequencer's BUSY line falls, the block captures a 15-bit magnitude with its polarity and overrange flags. The host reads them back as three bytes: a low byte, a high byte and a status byte. The data bus is driven only while the port is enabled, selected and read, and floats at all other times.

There are two modes. In demand mode the host chooses the byte with two select pins, and it starts each conversion by pulsing write while the port is enabled and selected. A demand-mode result is held until the next capture replaces it. In continuous mode the select pins have no effect. Each read returns the next byte of a fixed low, high, status sequence. The captured data also has a deadline, counted in oscillator clocks from the capture. When it passes, the stored bytes are wiped and a lost flag is raised.

Top module: `conv_bus_port`

## Requirements
- R1: `db` is high impedance on every bit unless `ce`, `cs` and `rd` are all high.
- R2: In demand mode (`cont_mode`=0) the driven byte is the status byte when `stat_sel`=1. When `stat_sel`=0 it is the high byte if `hi_sel`=1 and the low byte if `hi_sel`=0.
- R3: Byte formats are as follows. The low byte is result[7:0]. The high byte is {1'b0, result[14:8]}. The status byte has polarity in bit 7, overrange in bit 6 and zeros in bits 5..0.
- R4: `result`, `pol` and `ovr` are captured at the clock edge where `busy` is first seen low after being high. Later changes on those inputs do not reach `db`.
- R5: In continuous mode each read returns the next byte in the order low, high, status. A read that completes the status byte sends the next read back to the low byte. `hi_sel` and `stat_sel` have no effect in this mode. A read completes at the first clock edge that sees `rd` high with `ce` and `cs` high.
- R6: A capture returns the continuous read order to the low byte and clears `data_lost`.
- R7: In continuous mode the captured bytes stay readable for WINDOW_OSC clock edges after the capture edge. At the following edge they become all zero and `data_lost` goes to 1.
- R8: In demand mode the captured bytes stay readable with no time limit, through later BUSY-high periods, and `data_lost` stays 0.
- R9: In demand mode a rising edge of (`ce` & `cs` & `wr`) produces `start_pulse`=1 for exactly one cycle, after the clock edge that sees it. In continuous mode `start_pulse` stays 0.
- R10: After reset all three bytes read as zero, and `data_lost` and `start_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Chip enable |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, requests a demand-mode conversion |
| hi_sel | input | 1 | Demand-mode byte select: 1 selects the high byte |
| stat_sel | input | 1 | Demand-mode status select, takes priority over hi_sel |
| cont_mode | input | 1 | 1 selects continuous mode, 0 selects demand mode |
| busy | input | 1 | Sequencer BUSY; a falling edge marks a new result |
| result | input | RES_W | Converter magnitude |
| pol | input | 1 | Result polarity |
| ovr | input | 1 | Overrange flag |
| db | output | 8 | Tri-stated data bus |
| start_pulse | output | 1 | One-cycle conversion request |
| data_lost | output | 1 | Continuous-mode read window expired |

## Verification
The bench sets WINDOW_OSC to 20 instead of the default 1774. With that value the last clock edge at which the data can still be read, and the first edge at which it is wiped, are both reached in a few dozen cycles, so both sides of the deadline are checked exactly. RES_W stays at 15. A full-scale result therefore confirms that the high byte carries seven result bits with a zero in bit 7.

// File: rtl/conv_bus_port.sv
module conv_bus_port #(
  parameter int RES_W      = 15,
  parameter int WINDOW_OSC = 1774
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic             hi_sel,
  input  logic             stat_sel,
  input  logic             cont_mode,
  input  logic             busy,
  input  logic [RES_W-1:0] result,
  input  logic             pol,
  input  logic             ovr,
  output logic [7:0]       db,
  output logic             start_pulse,
  output logic             data_lost
);
  localparam int TW = $clog2(WINDOW_OSC + 1);

  logic [RES_W-1:0] res_r;
  logic             pol_r, ovr_r, busy_q, rd_q, wr_q, live;
  logic [1:0]       ptr;
  logic [TW-1:0]    tmr;
  logic [7:0]       lo_b, hi_b, st_b, sel_b;

  wire act     = ce & cs;
  wire capture = busy_q & ~busy;
  wire rd_edge = act & rd & ~rd_q;
  wire wr_act  = act & wr;
  wire expire  = cont_mode & live & (tmr == TW'(WINDOW_OSC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_r <= '0; pol_r <= 1'b0; ovr_r <= 1'b0;
      busy_q <= 1'b0; rd_q <= 1'b0; wr_q <= 1'b0;
      live <= 1'b0; ptr <= 2'd0; tmr <= '0;
      data_lost <= 1'b0; start_pulse <= 1'b0;
    end else begin
      busy_q      <= busy;
      rd_q        <= act & rd;
      wr_q        <= wr_act;
      start_pulse <= wr_act & ~wr_q & ~cont_mode;
      if (capture) begin
        res_r <= result; pol_r <= pol; ovr_r <= ovr;
        live <= 1'b1; ptr <= 2'd0; tmr <= '0; data_lost <= 1'b0;
      end else if (expire) begin
        res_r <= '0; pol_r <= 1'b0; ovr_r <= 1'b0;
        live <= 1'b0; data_lost <= 1'b1;
      end else begin
        if (cont_mode && live) tmr <= tmr + 1'b1;
        if (cont_mode && rd_edge) ptr <= (ptr == 2'd2) ? 2'd0 : ptr + 2'd1;
      end
    end
  end

  assign lo_b = res_r[7:0];
  assign hi_b = {{(16 - RES_W){1'b0}}, res_r[RES_W-1:8]};
  assign st_b = {pol_r, ovr_r, 6'd0};

  always_comb begin
    if (cont_mode)
      sel_b = (ptr == 2'd0) ? lo_b : (ptr == 2'd1) ? hi_b : st_b;
    else
      sel_b = stat_sel ? st_b : (hi_sel ? hi_b : lo_b);
  end

  assign db = (act & rd) ? sel_b : 8'hzz;
endmodule

// File: rtl/conv_bus_port_chk.sv
module conv_bus_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cont_mode,
  input logic       start_pulse,
  input logic       data_lost,
  input logic [1:0] ptr
);
  assert_order_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> (ptr == 2'd0) && !data_lost);

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr != 2'd3);

  assert_lost_cont_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_lost) |-> $past(cont_mode));

  assert_demand_no_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_mode && $past(!cont_mode) && !data_lost) |=> (!data_lost || $past(cont_mode)));

  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  assert_start_demand_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(cont_mode));
endmodule

bind conv_bus_port conv_bus_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cont_mode(cont_mode),
  .start_pulse(start_pulse), .data_lost(data_lost), .ptr(ptr)
);

// File: tb/sim_conv_bus_port.sv
module sim_conv_bus_port;
  localparam int RES_W = 15;
  localparam int WIN   = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 0, cs = 0, rd = 0, wr = 0, hi_sel = 0, stat_sel = 0, cont_mode = 0, busy = 0;
  logic [RES_W-1:0] result = '0;
  logic pol = 0, ovr = 0;
  wire  [7:0] db;
  wire  start_pulse, data_lost;
  int   n_chk = 0, n_err = 0;
  logic done = 0;

  always #2 clk = ~clk;

  conv_bus_port #(.RES_W(RES_W), .WINDOW_OSC(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cs(cs), .rd(rd), .wr(wr),
    .hi_sel(hi_sel), .stat_sel(stat_sel), .cont_mode(cont_mode), .busy(busy),
    .result(result), .pol(pol), .ovr(ovr), .db(db),
    .start_pulse(start_pulse), .data_lost(data_lost));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic convert(input logic [RES_W-1:0] r, input logic p, input logic o);
    @(negedge clk) busy = 1; result = r; pol = p; ovr = o;
    repeat (3) @(negedge clk);
    busy = 0;
    @(negedge clk);
  endtask

  task automatic read_byte(output logic [7:0] b);
    @(negedge clk) rd = 1;
    #1 b = db;
    @(negedge clk) rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] b;
    check("R10 lost", {7'd0, data_lost}, 8'd0);
    check("R10 start", {7'd0, start_pulse}, 8'd0);
    ce = 1; cs = 1;
    read_byte(b); check("R10 low", b, 8'h00);
    hi_sel = 1; read_byte(b); check("R10 high", b, 8'h00);
    stat_sel = 1; read_byte(b); check("R10 status", b, 8'h00);
    hi_sel = 0; stat_sel = 0;
  endtask

  task automatic t_float;
    @(negedge clk) ce = 1; cs = 1; rd = 0;
    #1 check("R1 rd low", db, 8'hzz);
    @(negedge clk) rd = 1; ce = 0;
    #1 check("R1 ce low", db, 8'hzz);
    @(negedge clk) ce = 1; cs = 0;
    #1 check("R1 cs low", db, 8'hzz);
    @(negedge clk) rd = 0; cs = 1;
  endtask

  task automatic t_demand;
    logic [7:0] b;
    cont_mode = 0;
    convert(15'h5A3C, 1'b1, 1'b0);
    result = 15'h0123; pol = 0; ovr = 1;
    read_byte(b); check("R2 R3 R4 low", b, 8'h3C);
    hi_sel = 1; read_byte(b); check("R2 R3 high", b, 8'h5A);
    stat_sel = 1; read_byte(b); check("R2 R3 status", b, 8'h80);
    hi_sel = 0; read_byte(b); check("R2 status priority", b, 8'h80);
    stat_sel = 0; read_byte(b); check("R2 low again", b, 8'h3C);
  endtask

  task automatic t_demand_hold;
    logic [7:0] b;
    cont_mode = 0;
    repeat (3 * WIN) @(negedge clk);
    @(negedge clk) busy = 1;
    repeat (5) @(negedge clk);
    read_byte(b); check("R8 held low", b, 8'h3C);
    hi_sel = 1; read_byte(b); check("R8 held high", b, 8'h5A);
    hi_sel = 0;
    check("R8 lost", {7'd0, data_lost}, 8'd0);
    @(negedge clk) busy = 0;
    @(negedge clk);
  endtask

  task automatic t_start;
    cont_mode = 0;
    @(negedge clk) wr = 1;
    @(negedge clk) check("R9 pulse", {7'd0, start_pulse}, 8'd1);
    @(negedge clk) check("R9 one cycle", {7'd0, start_pulse}, 8'd0);
    wr = 0;
    cont_mode = 1;
    @(negedge clk) wr = 1;
    @(negedge clk) check("R9 cont none", {7'd0, start_pulse}, 8'd0);
    wr = 0;
  endtask

  task automatic t_cont;
    logic [7:0] b;
    cont_mode = 1; hi_sel = 1; stat_sel = 1;
    convert(15'h7FFF, 1'b0, 1'b1);
    read_byte(b); check("R5 first low", b, 8'hFF);
    read_byte(b); check("R5 R3 high bit7 zero", b, 8'h7F);
    read_byte(b); check("R5 status", b, 8'h40);
    read_byte(b); check("R5 wrap low", b, 8'hFF);
    read_byte(b); check("R5 high", b, 8'h7F);
    convert(15'h1234, 1'b1, 1'b1);
    read_byte(b); check("R6 order back to low", b, 8'h34);
    hi_sel = 0; stat_sel = 0;
  endtask

  task automatic t_window;
    logic [7:0] b;
    cont_mode = 1;
    @(negedge clk) busy = 1; result = 15'h2A55; pol = 1; ovr = 1;
    repeat (3) @(negedge clk);
    busy = 0;
    @(negedge clk);
    repeat (WIN - 1) @(negedge clk);
    rd = 1;
    #1 check("R7 last valid", db, 8'h55);
    check("R7 not lost", {7'd0, data_lost}, 8'd0);
    @(negedge clk) rd = 0;
    #1 check("R7 lost set", {7'd0, data_lost}, 8'd1);
    read_byte(b); check("R7 wiped", b, 8'h00);
    convert(15'h0F0F, 1'b0, 1'b0);
    check("R6 lost cleared", {7'd0, data_lost}, 8'd0);
    read_byte(b); check("R6 fresh low", b, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_float();
    t_demand();
    t_demand_hold();
    t_start();
    t_cont();
    t_window();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule